// File: doc/BRIEF.md
# Serial EEPROM Page-Write Controller

This block is the receive side of a small serial EEPROM model, limited to the page-programming command. It oversamples the serial select, clock and data-in lines with the system clock. It shifts in an opcode, a 16-bit address and any number of data bytes, and gathers the data bytes in a one-page staging buffer. When select is released, it either launches a timed write cycle that copies the received bytes into the internal array, or it drops the command.

A separate one-byte command arms a write-enable latch, and every program command needs that latch. The latch clears by itself when an accepted write cycle ends. A two-bit protection level, applied from outside, can fence off the upper quarter, the upper half or the whole array. A side peek port reads the array combinationally so that its contents can be observed.

Top module: `eeprom_pagewrite`

## Requirements
- R1: Data-in is sampled on each rising serial clock edge while select is low, most significant bit first. The order is an 8-bit opcode, then a 16-bit address (high byte first), then data bytes.
- R2: An accepted program command (opcode 0x02) with one data byte stores that byte at the addressed location.
- R3: Successive data bytes in one command go to successive locations, starting at the given address, and all are committed in a single write cycle.
- R4: Only the low 5 address bits (offset within a 32-byte page) advance. After offset 31 the next byte goes to offset 0 of the same page, and a later byte replaces an earlier one at the same offset.
- R5: After acceptance, the busy output is high for exactly TWC_CYC clock cycles. When it falls, the write-enable latch is 0.
- R6: A program command issued while the write-enable latch is 0 changes nothing and starts no cycle.
- R7: A command (program or enable) that arrives while busy is high is ignored. It does not disturb the cycle in progress.
- R8: A program command is dropped if select rises when the bit count since the opcode is not a multiple of 8, or if no complete data byte was received.
- R9: Protection level encoding: 0 protects nothing, 1 protects addresses in the upper quarter of the array, 2 the upper half, 3 everything. A program command aimed at a protected page is dropped.
- R10: Address bits at and above ADDR_W are ignored.
- R11: Page locations that received no data in the command keep their previous contents.
- R12: Opcode 0x06 followed by select rising exactly after its 8th bit sets the write-enable latch. With any extra bits it is ignored.
- R13: The data-out enable output stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| prot_lvl | input | 2 | Protection level (R9 encoding) |
| peek_addr | input | ADDR_W | Array peek address |
| peek_data | output | 8 | Array contents at peek_addr |
| spi_miso_oe | output | 1 | Data-out drive enable, always 0 |
| wr_latch | output | 1 | Write-enable latch |
| wr_busy | output | 1 | Write cycle in progress |

## Verification
The assertions assume that the serial lines change slowly compared with the system clock: each serial clock level lasts at least two system clocks, and data-in is stable around every rising serial clock edge. They also assume that TWC_CYC is larger than the page size, so the copy into the array ends before busy drops. The bench drives every serial level for three system clocks and waits four clocks around each select edge. It keeps the protection level fixed for the duration of each command.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {PH_OPC, PH_AHI, PH_ALO, PH_DAT} pw_phase_t;
  localparam logic [7:0] OPC_ARM  = 8'h06;
  localparam logic [7:0] OPC_PROG = 8'h02;
endpackage

// File: rtl/pw_spi_rx.sv
module pw_spi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       sel_fall,
  output logic       sel_rise,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic       on_boundary
);
  logic [2:0] sck_q;
  logic [2:0] cs_q;
  logic [1:0] mosi_q;
  logic [6:0] shreg;
  logic [2:0] bitcnt;
  logic       sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 3'b000;
      cs_q   <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sel_fall = ~cs_q[1] & cs_q[2];
  assign sel_rise = cs_q[1] & ~cs_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (cs_q[1]) begin
      bitcnt <= '0;
    end else if (sck_rise) begin
      shreg  <= {shreg[5:0], mosi_q[1]};
      bitcnt <= bitcnt + 3'd1;
    end
  end

  assign byte_done   = sck_rise & ~cs_q[1] & (bitcnt == 3'd7);
  assign byte_val    = {shreg, mosi_q[1]};
  assign on_boundary = (bitcnt == 3'd0);
endmodule

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int PAGE_BYTES = 32,
  localparam int OFS_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [7:0]       wr_data,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [7:0]       rd_data,
  output logic             rd_valid
);
  logic [7:0]            slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] filled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled <= '0;
    end else if (clr) begin
      filled <= '0;
    end else if (wr_en) begin
      filled[wr_ofs] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_ofs] <= wr_data;
  end

  assign rd_data  = slot[rd_ofs];
  assign rd_valid = filled[rd_ofs];
endmodule

// File: rtl/pw_commit.sv
module pw_commit #(
  parameter int TWC_CYC    = 400,
  parameter int PAGE_BYTES = 32,
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int TMR_W = $clog2(TWC_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             cyc_done,
  output logic             scan_act,
  output logic [OFS_W-1:0] scan_ofs
);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(TWC_CYC - 1);
  localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(PAGE_BYTES - 1);
  logic [TMR_W-1:0] tmr;

  assign cyc_done = busy & (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tmr      <= '0;
      scan_act <= 1'b0;
      scan_ofs <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      tmr      <= TMR_LOAD;
      scan_act <= 1'b1;
      scan_ofs <= '0;
    end else if (busy) begin
      if (cyc_done) busy <= 1'b0;
      else tmr <= tmr - 1'b1;
      if (scan_act) begin
        if (scan_ofs == OFS_LAST) scan_act <= 1'b0;
        scan_ofs <= scan_ofs + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeprom_pagewrite.sv
module eeprom_pagewrite #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 32,
  parameter int TWC_CYC    = 400,
  localparam int MEM_BYTES = 1 << ADDR_W,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic [1:0]        prot_lvl,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [7:0]        peek_data,
  output logic              spi_miso_oe,
  output logic              wr_latch,
  output logic              wr_busy
);
  import pw_pkg::*;

  function automatic logic page_locked(input logic [1:0] lvl, input logic [ADDR_W-1:0] a);
    case (lvl)
      2'd0:    page_locked = 1'b0;
      2'd1:    page_locked = a[ADDR_W-1] & a[ADDR_W-2];
      2'd2:    page_locked = a[ADDR_W-1];
      default: page_locked = 1'b1;
    endcase
  endfunction

  logic             sel_fall, sel_rise, byte_done, on_boundary;
  logic [7:0]       byte_val;
  logic             cyc_done, scan_act;
  logic [OFS_W-1:0] scan_ofs;
  logic [7:0]       buf_rd;
  logic             buf_vld;

  pw_phase_t        phase;
  logic [7:0]       opcode;
  logic [15:0]      addr_r;
  logic [OFS_W-1:0] ofs;
  logic             have_data;
  logic [PG_W-1:0]  page_q;
  logic [7:0]       mem [MEM_BYTES];

  logic wr_accept, arm_ok, buf_we, buf_clr, mem_we;
  logic unused_hi;

  assign unused_hi = ^addr_r[15:ADDR_W];

  pw_spi_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .sel_fall(sel_fall), .sel_rise(sel_rise), .byte_done(byte_done),
    .byte_val(byte_val), .on_boundary(on_boundary)
  );

  assign buf_clr = sel_fall & ~wr_busy;
  assign buf_we  = byte_done & (phase == PH_DAT) & (opcode == OPC_PROG) & ~wr_busy;

  pw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_we), .wr_ofs(ofs),
    .wr_data(byte_val), .rd_ofs(scan_ofs), .rd_data(buf_rd), .rd_valid(buf_vld)
  );

  assign wr_accept = sel_rise & on_boundary & (phase == PH_DAT) & (opcode == OPC_PROG)
                   & have_data & wr_latch & ~wr_busy
                   & ~page_locked(prot_lvl, addr_r[ADDR_W-1:0]);
  assign arm_ok    = sel_rise & on_boundary & (phase == PH_AHI) & (opcode == OPC_ARM)
                   & ~wr_busy;

  pw_commit #(.TWC_CYC(TWC_CYC), .PAGE_BYTES(PAGE_BYTES)) u_commit (
    .clk(clk), .rst_n(rst_n), .start(wr_accept), .busy(wr_busy),
    .cyc_done(cyc_done), .scan_act(scan_act), .scan_ofs(scan_ofs)
  );

  // command decode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_OPC;
      opcode    <= '0;
      addr_r    <= '0;
      ofs       <= '0;
      have_data <= 1'b0;
    end else if (sel_fall) begin
      phase     <= PH_OPC;
      have_data <= 1'b0;
    end else if (byte_done) begin
      case (phase)
        PH_OPC: begin opcode <= byte_val; phase <= PH_AHI; end
        PH_AHI: begin addr_r[15:8] <= byte_val; phase <= PH_ALO; end
        PH_ALO: begin
          addr_r[7:0] <= byte_val;
          ofs         <= byte_val[OFS_W-1:0];
          phase       <= PH_DAT;
        end
        default: begin
          ofs       <= ofs + 1'b1;
          have_data <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_latch <= 1'b0;
    else if (cyc_done) wr_latch <= 1'b0;
    else if (arm_ok) wr_latch <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else if (wr_accept) page_q <= addr_r[ADDR_W-1:OFS_W];
  end

  assign mem_we = scan_act & buf_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (mem_we) begin
      mem[{page_q, scan_ofs}] <= buf_rd;
    end
  end

  assign peek_data   = mem[peek_addr];
  assign spi_miso_oe = 1'b0;
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int TWC_CYC = 400
) (
  input logic clk,
  input logic rst_n,
  input logic accept,
  input logic wel,
  input logic busy,
  input logic cyc_done,
  input logic mem_we
);
  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else if (!busy) busy_cnt <= 0;
    else busy_cnt <= busy_cnt + 1;
  end

  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept));  // R5
  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> (busy_cnt == TWC_CYC - 1));  // R5
  AST_LATCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> (!wel && !busy));  // R5
  AST_LATCH_BEFORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));  // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_done) |=> busy);  // R7
  AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);  // R11
endmodule

bind eeprom_pagewrite pw_checker #(.TWC_CYC(TWC_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(wr_accept), .wel(wr_latch),
  .busy(wr_busy), .cyc_done(cyc_done), .mem_we(mem_we)
);

// File: tb/eeprom_pagewrite_tb.sv
module eeprom_pagewrite_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 9;
  localparam int PAGE   = 32;
  localparam int TWC    = 400;
  localparam int HALF   = 3;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sck = 0, mosi = 0;
  logic [1:0] prot = 0;
  logic [ADDR_W-1:0] paddr = 0;
  logic [7:0] pdata;
  logic miso_oe, wel, busy;

  eeprom_pagewrite #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .TWC_CYC(TWC)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .prot_lvl(prot), .peek_addr(paddr), .peek_data(pdata),
    .spi_miso_oe(miso_oe), .wr_latch(wel), .wr_busy(busy));

  always #(CLK_P/2) clk = ~clk;

  int errs = 0, checks = 0;
  int busy_total = 0;
  logic [7:0] refm [MEMSZ];
  logic [7:0] dbuf [40];
  logic m_wel = 0;

  always @(negedge clk) if (busy) busy_total++;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = b[i];
      repeat (HALF) @(negedge clk);
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic xfer(input logic [7:0] op, input logic [15:0] a, input int n, input int extra);
    @(negedge clk);
    cs_n = 0;
    repeat (4) @(negedge clk);
    send_bits(op, 8);
    if (op != 8'h06) begin
      send_bits(a[15:8], 8);
      send_bits(a[7:0], 8);
    end
    for (int i = 0; i < n; i++) send_bits(dbuf[i], 8);
    if (extra > 0) send_bits(8'hA5, extra);
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic locked(input logic [1:0] lvl, input int a);
    int lim;
    lim = (lvl == 0) ? MEMSZ : (lvl == 3) ? 0 : MEMSZ - (MEMSZ / 4) * lvl;
    return a >= lim;
  endfunction

  task automatic arm(input int extra);
    xfer(8'h06, 16'h0, 0, extra);
    if (extra == 0) m_wel = 1;
  endtask

  task automatic check_page(input int a, input string tag);
    int base;
    base = a & ~(PAGE - 1);
    for (int o = 0; o < PAGE; o++) begin
      paddr = ADDR_W'(base + o);
      #1;
      chk(pdata, refm[base + o], tag);
    end
  endtask

  // full program command with model update and checks
  task automatic prog(input logic [15:0] a, input int n, input int extra, input string tag);
    logic acc;
    int st, o, pg;
    pg  = int'(a[ADDR_W-1:0]) & ~(PAGE - 1);
    acc = (n > 0) && (extra == 0) && m_wel && !locked(prot, int'(a[ADDR_W-1:0]));
    st  = busy_total;
    xfer(8'h02, a, n, extra);
    repeat (TWC + 30) @(negedge clk);
    if (acc) begin
      o = int'(a) % PAGE;
      for (int i = 0; i < n; i++) begin
        refm[pg + o] = dbuf[i];
        o = (o + 1) % PAGE;
      end
      m_wel = 0;
    end
    chk(busy_total - st, acc ? TWC : 0, {tag, " R5 busy length"});
    chk(wel, m_wel, {tag, " R5 latch"});
    check_page(pg, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMSZ; i++) refm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(busy, 0, "reset busy");
    chk(wel, 0, "reset latch");
    chk(miso_oe, 0, "R13 reset");

    // R12: enable with stray bits ignored, clean enable sets latch
    arm(3);
    chk(wel, 0, "R12 misaligned enable");
    // R6: program with latch clear
    dbuf[0] = 8'h3C;
    prog(16'h0040, 1, 0, "R6 no latch");
    arm(0);
    chk(wel, 1, "R12 enable");
    // R2 single byte
    dbuf[0] = 8'h5A;
    prog(16'h0047, 1, 0, "R2 R1 single");

    // R3 R4 R11 sweep of start offsets, 3 bytes each, page rotates
    for (int s = 0; s < PAGE; s++) begin
      for (int i = 0; i < 3; i++) dbuf[i] = 8'((s * 7 + i * 29 + 1) & 8'hFF);
      arm(0);
      prog(16'((s % 16) * PAGE + s), 3, 0, "R3 R4 R11 sweep");
    end

    // R4 overwrite beyond one page
    for (int i = 0; i < 35; i++) dbuf[i] = 8'(8'h80 + i);
    arm(0);
    prog(16'h00A4, 35, 0, "R4 overfill");

    // R8 misaligned end and missing data
    dbuf[0] = 8'hEE; dbuf[1] = 8'hEF;
    arm(0);
    prog(16'h0061, 2, 5, "R8 misaligned");
    prog(16'h0061, 0, 0, "R8 no data");

    // R10 high address bits ignored
    dbuf[0] = 8'h77;
    prog(16'hFE05, 1, 0, "R10 high bits");

    // R7 commands during busy
    arm(0);
    dbuf[0] = 8'h11;
    xfer(8'h02, 16'h0022, 1, 0);
    refm[16'h0022] = 8'h11;
    chk(busy, 1, "R7 first busy");
    dbuf[0] = 8'h99;
    xfer(8'h02, 16'h0143, 1, 0);
    arm(0);
    m_wel = 0;
    repeat (TWC + 30) @(negedge clk);
    chk(busy, 0, "R7 busy end");
    chk(wel, 0, "R7 enable during busy");
    check_page(16'h0022, "R7 first page");
    check_page(16'h0143, "R7 second ignored");

    // R9 protection sweep
    for (int l = 0; l < 4; l++) begin
      prot = 2'(l);
      for (int k = 0; k < 4; k++) begin
        int a;
        a = k * (MEMSZ / 4) + 3;
        dbuf[0] = 8'(l * 16 + k + 1);
        arm(0);
        prog(16'(a), 1, 0, "R9 protect");
        m_wel = wel;
      end
    end
    prot = 0;
    chk(miso_oe, 0, "R13 end");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule